// File: doc/BRIEF.md
# Partitioned Receive Rule Table

This block holds the acceptance rules for a two-channel message receiver in one shared table. Each channel has a rule count register. Channel 0 owns the lowest entries. Each later channel owns the entries that follow directly after the previous channel's region. Rule numbers restart at zero inside each region. Entries beyond the sum of the counts are unused. When the counts ask for more entries than the table holds, the excess is clamped away and an error flag is raised.

Software reads and writes the table through a sixteen-entry window. A control register holds a page number and a write-enable bit. Window writes only take effect while that bit is set. A window read returns the entry at the current page and the given slot.

A received frame arrives with its channel number and identifier. The block scans that channel's region only, in ascending order, one rule per clock. It stops at the first rule whose stored identifier agrees with the frame identifier on every bit where the rule's mask is one. It then gives a one-cycle result carrying a hit flag, the destination buffer index and the local rule number. A channel with zero rules drops every frame.

Top module: `rule_partition_table`

## Requirements
- R1: After reset the following are all zero: the counts, the page number, the write-enable bit, every table entry, `busy`, `res_done` and `cfg_err`.
- R2: A window write stores identifier, mask and destination at table index page*16+slot when the write-enable bit is set. When the bit is clear, the write leaves the table unchanged.
- R3: The page field (3 bits) selects one of eight 16-entry groups, so that pages 0 to 7 together expose all 128 entries through the window read port.
- R4: A rule matches when ((frame_id XOR rule_id) AND rule_mask) is zero. A mask bit of 0 makes that identifier bit don't-care.
- R5: Channel 0 rule k sits at table index k. Channel 1 rule k sits at index (granted channel 0 count + k). A frame is compared only against its own channel's region.
- R6: A frame on a channel whose granted count is zero is dropped: res_hit=0, res_dest=0, res_rule=0.
- R7: The lowest-numbered matching rule of the region wins. res_rule reports its local number and res_dest its destination. On a miss, res_dest and res_rule are 0.
- R8: res_done is a single-cycle pulse, asserted N clock edges after the edge that accepts the frame. N is k+1 for a hit at local rule k, the region size for a miss in a non-empty region, and 1 for an empty region.
- R9: While busy is high, frame inputs are ignored: no second result is produced for them.
- R10: The channel 0 grant is min(count0, 128). The channel 1 grant is min(count1, 128 minus the channel 0 grant). cfg_err is 1 exactly when count0+count1 exceeds 128.
- R11: busy is high from the accepting edge until the edge that raises res_done, and low in the cycle where res_done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_wr | input | 1 | Write strobe for a channel rule count |
| cnt_sel | input | 1 | Channel whose count is written |
| cnt_data | input | 8 | New rule count |
| cfg_err | output | 1 | Counts ask for more rules than the table holds |
| ctl_wr | input | 1 | Write strobe for page and write-enable |
| ctl_page | input | 3 | Page number to select |
| ctl_wen | input | 1 | Table write-enable value |
| win_page | output | 3 | Current page number |
| win_wen | output | 1 | Current write-enable bit |
| win_wr | input | 1 | Window write strobe |
| win_addr | input | 4 | Slot within the page for the write |
| win_id | input | 11 | Identifier to store |
| win_mask | input | 11 | Mask to store |
| win_dest | input | 5 | Destination buffer index to store |
| win_rd_addr | input | 4 | Slot within the page for the read |
| win_rd_id | output | 11 | Stored identifier at the read slot |
| win_rd_mask | output | 11 | Stored mask at the read slot |
| win_rd_dest | output | 5 | Stored destination at the read slot |
| frm_valid | input | 1 | Frame present |
| frm_chan | input | 1 | Frame channel |
| frm_id | input | 11 | Frame identifier |
| busy | output | 1 | Scan in progress |
| res_done | output | 1 | Result pulse |
| res_hit | output | 1 | A rule matched |
| res_dest | output | 5 | Destination of the matching rule |
| res_rule | output | 8 | Local number of the matching rule |

## Verification
The assertions assume three things:
- Software leaves the counts and the table untouched while a scan is running.
- The channel number always names an existing channel.
- Once a scan is accepted, it finishes without interference from any input.

The stimulus keeps to these assumptions. Every count write, control write and window access is issued only after the previous result pulse has been seen. The only frame input driven during a scan is the deliberate one that tests that busy frames are ignored.

// File: rtl/rrt_pkg.sv
package rrt_pkg;

  typedef enum logic {SC_IDLE = 1'b0, SC_RUN = 1'b1} scan_state_t;

  // Grant at most the space still free in the table.
  function automatic int unsigned clamp_to(int unsigned want, int unsigned room);
    return (want > room) ? room : want;
  endfunction

  // Identifier comparison under a care mask (1 = bit must agree).
  function automatic logic masked_eq(logic [31:0] a, logic [31:0] b, logic [31:0] m);
    return ((a ^ b) & m) == 32'd0;
  endfunction

  // Absolute table position of a region-relative entry.
  function automatic int unsigned local_slot(int unsigned base, int unsigned k);
    return base + k;
  endfunction

endpackage

// File: rtl/rrt_bounds.sv
module rrt_bounds
  import rrt_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DEPTH  = 128,
  parameter int CNT_W  = 8,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cnt_wr,
  input  logic [CH_W-1:0]                cnt_sel,
  input  logic [CNT_W-1:0]               cnt_data,
  output logic [NUM_CH-1:0][CNT_W-1:0]   eff,
  output logic [NUM_CH-1:0][CNT_W-1:0]   base,
  output logic                           cfg_err
);

  logic [NUM_CH-1:0][CNT_W-1:0] cnt_q;
  logic [31:0] eff_total;
  logic [31:0] raw_total;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_wr && (32'(cnt_sel) < NUM_CH)) begin
      cnt_q[cnt_sel] <= cnt_data;
    end
  end

  // Regions are laid end to end; each grant is limited by what is left.
  always_comb begin
    int unsigned used;
    int unsigned raw;
    int unsigned grant;
    used  = 0;
    raw   = 0;
    grant = 0;
    for (int c = 0; c < NUM_CH; c++) begin
      grant   = clamp_to(32'(cnt_q[c]), DEPTH - used);
      base[c] = CNT_W'(used);
      eff[c]  = CNT_W'(grant);
      used    = used + grant;
      raw     = raw + 32'(cnt_q[c]);
    end
    eff_total = used;
    raw_total = raw;
  end

  assign cfg_err = (raw_total > DEPTH);

  AST_CLEAN_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_err |-> (eff_total == raw_total)); // R10
  AST_OVER_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (eff_total == DEPTH)); // R10

endmodule

// File: rtl/rrt_store.sv
module rrt_store
  import rrt_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int ID_W   = 11,
  parameter int DEST_W = 5,
  parameter int WIN    = 16,
  localparam int WIN_W = $clog2(WIN),
  localparam int PG_W  = (DEPTH / WIN > 1) ? $clog2(DEPTH / WIN) : 1,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [PG_W-1:0]   ctl_page,
  input  logic              ctl_wen,
  output logic [PG_W-1:0]   win_page,
  output logic              win_wen,
  input  logic              win_wr,
  input  logic [WIN_W-1:0]  win_addr,
  input  logic [ID_W-1:0]   win_id,
  input  logic [ID_W-1:0]   win_mask,
  input  logic [DEST_W-1:0] win_dest,
  input  logic [WIN_W-1:0]  win_rd_addr,
  output logic [ID_W-1:0]   win_rd_id,
  output logic [ID_W-1:0]   win_rd_mask,
  output logic [DEST_W-1:0] win_rd_dest,
  input  logic [IDX_W-1:0]  scan_idx,
  output logic [ID_W-1:0]   scan_id,
  output logic [ID_W-1:0]   scan_mask,
  output logic [DEST_W-1:0] scan_dest
);

  logic [PG_W-1:0]   page_q;
  logic              wen_q;
  logic [IDX_W-1:0]  wr_idx;
  logic [IDX_W-1:0]  rd_idx;
  logic              wr_fire;
  logic              locked_drop;

  logic [ID_W-1:0]   id_mem   [DEPTH];
  logic [ID_W-1:0]   mask_mem [DEPTH];
  logic [DEST_W-1:0] dest_mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      wen_q  <= 1'b0;
    end else if (ctl_wr) begin
      page_q <= ctl_page;
      wen_q  <= ctl_wen;
    end
  end

  assign wr_idx      = IDX_W'(local_slot(32'(page_q) * WIN, 32'(win_addr)));
  assign rd_idx      = IDX_W'(local_slot(32'(page_q) * WIN, 32'(win_rd_addr)));
  assign wr_fire     = win_wr && wen_q;
  assign locked_drop = win_wr && !wen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        id_mem[i]   <= '0;
        mask_mem[i] <= '0;
        dest_mem[i] <= '0;
      end
    end else if (wr_fire) begin
      id_mem[wr_idx]   <= win_id;
      mask_mem[wr_idx] <= win_mask;
      dest_mem[wr_idx] <= win_dest;
    end
  end

  assign win_page    = page_q;
  assign win_wen     = wen_q;
  assign win_rd_id   = id_mem[rd_idx];
  assign win_rd_mask = mask_mem[rd_idx];
  assign win_rd_dest = dest_mem[rd_idx];
  assign scan_id     = id_mem[scan_idx];
  assign scan_mask   = mask_mem[scan_idx];
  assign scan_dest   = dest_mem[scan_idx];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> (id_mem[$past(wr_idx)] == $past(win_id))); // R2
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    locked_drop |=> (id_mem[$past(wr_idx)] == $past(id_mem[wr_idx]))); // R2

endmodule

// File: rtl/rrt_scan.sv
module rrt_scan
  import rrt_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DEPTH  = 128,
  parameter int CNT_W  = 8,
  parameter int ID_W   = 11,
  parameter int DEST_W = 5,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          frm_valid,
  input  logic [CH_W-1:0]               frm_chan,
  input  logic [ID_W-1:0]               frm_id,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  eff,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  base,
  output logic [IDX_W-1:0]              scan_idx,
  input  logic [ID_W-1:0]               scan_id,
  input  logic [ID_W-1:0]               scan_mask,
  input  logic [DEST_W-1:0]             scan_dest,
  output logic                          busy,
  output logic                          res_done,
  output logic                          res_hit,
  output logic [DEST_W-1:0]             res_dest,
  output logic [CNT_W-1:0]              res_rule
);

  scan_state_t      state_q;
  logic [CNT_W-1:0] s_base;
  logic [CNT_W-1:0] s_cnt;
  logic [CNT_W-1:0] k_q;
  logic [ID_W-1:0]  s_id;

  logic chan_ok;
  logic accept;
  logic region_empty;
  logic at_last;
  logic rule_hit;
  logic found;
  logic finish;

  assign chan_ok      = (32'(frm_chan) < NUM_CH);
  assign accept       = frm_valid && (state_q == SC_IDLE);
  assign region_empty = (s_cnt == '0);
  assign at_last      = region_empty || (k_q == s_cnt - CNT_W'(1));
  assign rule_hit     = masked_eq(32'(s_id), 32'(scan_id), 32'(scan_mask));
  assign found        = !region_empty && rule_hit;
  assign finish       = (state_q == SC_RUN) && (found || at_last);
  assign scan_idx     = IDX_W'(local_slot(32'(s_base), 32'(k_q)));
  assign busy         = (state_q == SC_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SC_IDLE;
      s_base   <= '0;
      s_cnt    <= '0;
      k_q      <= '0;
      s_id     <= '0;
      res_done <= 1'b0;
      res_hit  <= 1'b0;
      res_dest <= '0;
      res_rule <= '0;
    end else begin
      res_done <= 1'b0;
      case (state_q)
        SC_IDLE: begin
          if (accept) begin
            s_base  <= chan_ok ? base[frm_chan] : '0;
            s_cnt   <= chan_ok ? eff[frm_chan] : '0;
            s_id    <= frm_id;
            k_q     <= '0;
            state_q <= SC_RUN;
          end
        end
        SC_RUN: begin
          if (finish) begin
            res_done <= 1'b1;
            res_hit  <= found;
            res_dest <= found ? scan_dest : '0;
            res_rule <= found ? k_q : '0;
            state_q  <= SC_IDLE;
          end else begin
            k_q <= k_q + CNT_W'(1);
          end
        end
        default: state_q <= SC_IDLE;
      endcase
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |=> !res_done); // R8
  AST_IDX_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !region_empty) |-> ((32'(scan_idx) >= 32'(s_base)) && (32'(scan_idx) < 32'(s_base) + 32'(s_cnt)))); // R5
  AST_EMPTY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && region_empty) |=> (res_done && !res_hit)); // R6
  AST_HIT_WITHIN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && res_hit) |-> (res_rule < s_cnt)); // R7
  AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !res_done) |=> (busy || res_done)); // R11
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> !busy); // R11
  AST_IGNORE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && frm_valid) |=> $stable(s_id)); // R9

endmodule

// File: rtl/rule_partition_table.sv
module rule_partition_table
  import rrt_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ID_W   = 11,
  parameter int DEST_W = 5,
  parameter int CNT_W  = 8,
  parameter int WIN    = 16,
  localparam int DEPTH = (64 * NUM_CH < 128) ? 64 * NUM_CH : 128,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int WIN_W = $clog2(WIN),
  localparam int PG_W  = (DEPTH / WIN > 1) ? $clog2(DEPTH / WIN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_wr,
  input  logic [CH_W-1:0]   cnt_sel,
  input  logic [CNT_W-1:0]  cnt_data,
  output logic              cfg_err,
  input  logic              ctl_wr,
  input  logic [PG_W-1:0]   ctl_page,
  input  logic              ctl_wen,
  output logic [PG_W-1:0]   win_page,
  output logic              win_wen,
  input  logic              win_wr,
  input  logic [WIN_W-1:0]  win_addr,
  input  logic [ID_W-1:0]   win_id,
  input  logic [ID_W-1:0]   win_mask,
  input  logic [DEST_W-1:0] win_dest,
  input  logic [WIN_W-1:0]  win_rd_addr,
  output logic [ID_W-1:0]   win_rd_id,
  output logic [ID_W-1:0]   win_rd_mask,
  output logic [DEST_W-1:0] win_rd_dest,
  input  logic              frm_valid,
  input  logic [CH_W-1:0]   frm_chan,
  input  logic [ID_W-1:0]   frm_id,
  output logic              busy,
  output logic              res_done,
  output logic              res_hit,
  output logic [DEST_W-1:0] res_dest,
  output logic [CNT_W-1:0]  res_rule
);

  localparam int IDX_W = $clog2(DEPTH);

  logic [NUM_CH-1:0][CNT_W-1:0] eff;
  logic [NUM_CH-1:0][CNT_W-1:0] base;
  logic [IDX_W-1:0]             scan_idx;
  logic [ID_W-1:0]              scan_id;
  logic [ID_W-1:0]              scan_mask;
  logic [DEST_W-1:0]            scan_dest;

  rrt_bounds #(.NUM_CH(NUM_CH), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_bounds (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_wr   (cnt_wr),
    .cnt_sel  (cnt_sel),
    .cnt_data (cnt_data),
    .eff      (eff),
    .base     (base),
    .cfg_err  (cfg_err)
  );

  rrt_store #(.DEPTH(DEPTH), .ID_W(ID_W), .DEST_W(DEST_W), .WIN(WIN)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_wr      (ctl_wr),
    .ctl_page    (ctl_page),
    .ctl_wen     (ctl_wen),
    .win_page    (win_page),
    .win_wen     (win_wen),
    .win_wr      (win_wr),
    .win_addr    (win_addr),
    .win_id      (win_id),
    .win_mask    (win_mask),
    .win_dest    (win_dest),
    .win_rd_addr (win_rd_addr),
    .win_rd_id   (win_rd_id),
    .win_rd_mask (win_rd_mask),
    .win_rd_dest (win_rd_dest),
    .scan_idx    (scan_idx),
    .scan_id     (scan_id),
    .scan_mask   (scan_mask),
    .scan_dest   (scan_dest)
  );

  rrt_scan #(.NUM_CH(NUM_CH), .DEPTH(DEPTH), .CNT_W(CNT_W), .ID_W(ID_W), .DEST_W(DEST_W)) u_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .frm_valid (frm_valid),
    .frm_chan  (frm_chan),
    .frm_id    (frm_id),
    .eff       (eff),
    .base      (base),
    .scan_idx  (scan_idx),
    .scan_id   (scan_id),
    .scan_mask (scan_mask),
    .scan_dest (scan_dest),
    .busy      (busy),
    .res_done  (res_done),
    .res_hit   (res_hit),
    .res_dest  (res_dest),
    .res_rule  (res_rule)
  );

  AST_RESULT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && !res_hit) |-> (res_dest == '0 && res_rule == '0)); // R7

endmodule

// File: tb/sim_rule_partition_table.sv
`timescale 1ns/1ps
module sim_rule_partition_table;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_wr = 1'b0;
  logic [0:0]  cnt_sel = '0;
  logic [7:0]  cnt_data = '0;
  logic        cfg_err;
  logic        ctl_wr = 1'b0;
  logic [2:0]  ctl_page = '0;
  logic        ctl_wen = 1'b0;
  logic [2:0]  win_page;
  logic        win_wen;
  logic        win_wr = 1'b0;
  logic [3:0]  win_addr = '0;
  logic [10:0] win_id = '0;
  logic [10:0] win_mask = '0;
  logic [4:0]  win_dest = '0;
  logic [3:0]  win_rd_addr = '0;
  logic [10:0] win_rd_id;
  logic [10:0] win_rd_mask;
  logic [4:0]  win_rd_dest;
  logic        frm_valid = 1'b0;
  logic [0:0]  frm_chan = '0;
  logic [10:0] frm_id = '0;
  logic        busy;
  logic        res_done;
  logic        res_hit;
  logic [4:0]  res_dest;
  logic [7:0]  res_rule;

  always #2 clk = ~clk;

  rule_partition_table u0 (
    .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .cnt_sel(cnt_sel), .cnt_data(cnt_data),
    .cfg_err(cfg_err), .ctl_wr(ctl_wr), .ctl_page(ctl_page), .ctl_wen(ctl_wen),
    .win_page(win_page), .win_wen(win_wen), .win_wr(win_wr), .win_addr(win_addr),
    .win_id(win_id), .win_mask(win_mask), .win_dest(win_dest), .win_rd_addr(win_rd_addr),
    .win_rd_id(win_rd_id), .win_rd_mask(win_rd_mask), .win_rd_dest(win_rd_dest),
    .frm_valid(frm_valid), .frm_chan(frm_chan), .frm_id(frm_id), .busy(busy),
    .res_done(res_done), .res_hit(res_hit), .res_dest(res_dest), .res_rule(res_rule)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  int m_id [128];
  int m_mask [128];
  int m_dest [128];

  task automatic check_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_count(int ch, int v);
    @(negedge clk); cnt_wr = 1'b1; cnt_sel = ch[0:0]; cnt_data = v[7:0];
    @(negedge clk); cnt_wr = 1'b0;
  endtask

  task automatic set_ctl(int pg, bit en);
    @(negedge clk); ctl_wr = 1'b1; ctl_page = pg[2:0]; ctl_wen = en;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic win_write(int a, int id, int mask, int dest);
    @(negedge clk); win_wr = 1'b1; win_addr = a[3:0];
    win_id = id[10:0]; win_mask = mask[10:0]; win_dest = dest[4:0];
    @(negedge clk); win_wr = 1'b0;
  endtask

  // Region grants restated from R10.
  task automatic grants(input int c0, input int c1, output int e0, output int e1);
    int spare;
    e0 = (c0 < 128) ? c0 : 128;
    spare = 128 - e0;
    e1 = (c1 < spare) ? c1 : spare;
  endtask

  // Expected result from R4..R8.
  task automatic model(input int ch, input int id, input int e0, input int e1,
                       output bit hit, output int dest, output int rule, output int lat);
    int start;
    int n;
    start = (ch == 0) ? 0 : e0;
    n = (ch == 0) ? e0 : e1;
    hit = 1'b0; dest = 0; rule = 0;
    lat = (n == 0) ? 1 : n;
    for (int k = 0; k < n; k++) begin
      if (!hit && (((id ^ m_id[start + k]) & m_mask[start + k] & 'h7FF) == 0)) begin
        hit = 1'b1; dest = m_dest[start + k]; rule = k; lat = k + 1;
      end
    end
  endtask

  task automatic send_frame(int ch, int id, int e0, int e1, bit inject, string req);
    bit ehit;
    int edest, erule, elat, lat;
    bit extra;
    model(ch, id, e0, e1, ehit, edest, erule, elat);
    @(negedge clk); frm_valid = 1'b1; frm_chan = ch[0:0]; frm_id = id[10:0];
    @(negedge clk); frm_valid = 1'b0;
    check_eq("R11", "busy after accept", int'(busy), 1);
    lat = 0;
    while (!res_done && lat < 400) begin
      @(negedge clk);
      lat++;
      if (inject && lat == 2) begin
        frm_valid = 1'b1; frm_chan = ~ch[0:0]; frm_id = 11'h000;
      end
      if (inject && lat == 3) frm_valid = 1'b0;
    end
    check_eq(req, "hit", int'(res_hit), int'(ehit));
    check_eq("R7", "dest", int'(res_dest), edest);
    check_eq("R7", "rule", int'(res_rule), erule);
    check_eq("R8", "latency", lat, elat);
    check_eq("R11", "busy at done", int'(busy), 0);
    if (inject) begin
      extra = 1'b0;
      repeat (80) begin
        @(negedge clk);
        if (res_done) extra = 1'b1;
      end
      check_eq("R9", "extra result", int'(extra), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL R8 watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int cfg0 [6];
    int cfg1 [6];
    int e0, e1;
    cfg0 = '{5, 0, 3, 60, 200, 100};
    cfg1 = '{4, 3, 0, 48, 50, 40};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_eq("R1", "busy", int'(busy), 0);
    check_eq("R1", "res_done", int'(res_done), 0);
    check_eq("R1", "cfg_err", int'(cfg_err), 0);
    check_eq("R1", "page", int'(win_page), 0);
    check_eq("R1", "wen", int'(win_wen), 0);
    win_rd_addr = 4'd7; #1;
    check_eq("R1", "entry id", int'(win_rd_id), 0);
    check_eq("R1", "entry mask", int'(win_rd_mask), 0);

    // Program all pages through the window.
    for (int i = 0; i < 128; i++) begin
      m_id[i]   = (i * 53 + 7) % 2048;
      m_mask[i] = (i == 90) ? 0 : ((i % 4 == 3) ? 'h7C0 : 'h7FF);
      m_dest[i] = i % 32;
    end
    for (int p = 0; p < 8; p++) begin
      set_ctl(p, 1'b1);
      check_eq("R3", "page field", int'(win_page), p);
      for (int a = 0; a < 16; a++)
        win_write(a, m_id[p*16+a], m_mask[p*16+a], m_dest[p*16+a]);
    end
    for (int p = 0; p < 8; p++) begin
      set_ctl(p, 1'b1);
      for (int a = 0; a < 16; a++) begin
        win_rd_addr = a[3:0]; #1;
        check_eq("R3", "readback id", int'(win_rd_id), m_id[p*16+a]);
        checks++;
        if (int'(win_rd_mask) != m_mask[p*16+a] || int'(win_rd_dest) != m_dest[p*16+a]) begin
          errors++;
          $display("FAIL R2 mask/dest at %0d actual=%0d/%0d expected=%0d/%0d", p*16+a,
                   win_rd_mask, win_rd_dest, m_mask[p*16+a], m_dest[p*16+a]);
        end
      end
    end

    // R2 writes with enable clear are dropped.
    set_ctl(2, 1'b0);
    check_eq("R2", "wen cleared", int'(win_wen), 0);
    win_write(5, 'h123, 'h0, 9);
    @(negedge clk); win_rd_addr = 4'd5; #1;
    check_eq("R2", "locked id", int'(win_rd_id), m_id[37]);
    check_eq("R2", "locked mask", int'(win_rd_mask), m_mask[37]);
    check_eq("R2", "locked dest", int'(win_rd_dest), m_dest[37]);

    for (int c = 0; c < 6; c++) begin
      set_count(0, cfg0[c]);
      set_count(1, cfg1[c]);
      @(negedge clk);
      check_eq("R10", "cfg_err", int'(cfg_err), int'((cfg0[c] + cfg1[c]) > 128));
      grants(cfg0[c], cfg1[c], e0, e1);
      for (int ch = 0; ch < 2; ch++) begin
        int n, start, step;
        n = (ch == 0) ? e0 : e1;
        start = (ch == 0) ? 0 : e0;
        step = (n > 24) ? 5 : 1;
        if (n == 0) begin
          send_frame(ch, 'h000, e0, e1, 1'b0, "R6");
          send_frame(ch, 'h7FF, e0, e1, 1'b0, "R6");
          send_frame(ch, m_id[0], e0, e1, 1'b0, "R6");
        end
        for (int k = 0; k < n; k += step)
          send_frame(ch, m_id[start + k], e0, e1, 1'b0, "R5");
        if (n > 3) send_frame(ch, m_id[start + 3] ^ 'h015, e0, e1, 1'b0, "R4");
        send_frame(ch, m_id[start] ^ 'h2AA, e0, e1, 1'b0, "R4");
      end
      if (c == 0) send_frame(1, m_id[0], e0, e1, 1'b0, "R5");
      if (c == 3) send_frame(0, m_id[100], e0, e1, 1'b1, "R9");
      if (c == 5) send_frame(0, m_id[95], e0, e1, 1'b0, "R7");
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule